// File: doc/BRIEF.md
# Page Protection and Fault Classifier

This block rules on a single 32-bit effective-address access. It returns whether the access is allowed, which read/write/execute rights apply, and which fault to report when it is not allowed. The access comes with its kind (instruction fetch, data load or data store), its privilege level and a flag for untranslated (real) mode. The block also receives the outcome of an external block-translation match and the outcome of an external page-table search, which carries the protection field of the matching entry. The block holds the sixteen segment registers itself. The top four address bits select one of them.

The checks run in a fixed order:
- real mode;
- a block-translation hit;
- a direct-store segment;
- a segment no-execute veto on fetches;
- a missing page-table entry;
- the page protection check.

Each fault cause produces a fixed 32-bit status word. An instruction fault or a data fault is raised, never both. A data fault also latches the effective address into a fault-address register. All results are registered and appear one clock after the request strobe.

Segment register layout, as written through the segment write port:
- bit 31: direct-store segment.
- bit 30: supervisor key.
- bit 29: user key.
- bit 28: no-execute.
- the remaining bits are stored but not used.

Permission vector bits: bit 0 read, bit 1 write, bit 2 execute. Access kind encoding: 0 fetch, 1 load, 2 store (3 is treated as a load).

Top module: `access_guard`

## Requirements
- R1: `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high. The other response outputs change only in that cycle and otherwise hold their last value.
- R2: With `req_real` set, the access is granted with permission 3'b111 and status 0, whatever the segment, block and table inputs are.
- R3: Sixteen segment registers are written through `seg_we`/`seg_idx`/`seg_wdata` and read by `req_ea[31:28]`. All of them reset to zero, and a later write replaces the earlier value.
- R4: When not in real mode, a block hit decides the outcome alone. Its protection field gives no rights for 0, read+execute for 1 or 3, and read+write+execute for 2.
- R5: A protection violation, from either a block hit or a page entry, reports status 0x08000000 for a fetch or a load and 0x0A000000 for a store.
- R6: A fetch to a segment with no-execute (bit 28) set raises an instruction fault with status 0x10000000, even when no page-table entry was found.
- R7: In a direct-store segment (bit 31), a fetch is refused with status 0x10000000. A data access there gets read only when the selected key is 0 and read+write when it is 1, checked with the R5 codes. The table inputs are ignored.
- R8: When no page-table entry is found, the status is 0x40000000 for a fetch or a load and 0x42000000 for a store.
- R9: The key is segment bit 29 for user accesses (`req_user`=1) and bit 30 for supervisor accesses.
- R10: Page rights: with key 0, field values 0, 1 and 2 give read+write and 3 gives read. With key 1, value 0 gives nothing, 1 and 3 give read, and 2 gives read+write.
- R11: Page execute right is added only when segment bit 28 is clear. A fetch needs execute, a load needs read and a store needs write.
- R12: A fetch fault raises only `rsp_ifault` and a data fault raises only `rsp_dfault`. A grant has both flags low and status 0.
- R13: `fault_addr` takes `req_ea` on every data fault and is left unchanged by grants and instruction faults. It resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_idx | input | 4 | Segment register write index |
| seg_wdata | input | 32 | Segment register write data |
| req_vld | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| req_real | input | 1 | Translation off |
| req_ea | input | 32 | Effective address |
| blk_hit | input | 1 | Block translation matched |
| blk_pp | input | 2 | Protection field of the matching block |
| pte_found | input | 1 | Page-table search found an entry |
| pte_pp | input | 2 | Protection field of the found entry |
| rsp_vld | output | 1 | Response valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_perm | output | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| rsp_ifault | output | 1 | Instruction storage fault |
| rsp_dfault | output | 1 | Data storage fault |
| rsp_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Address of the last data fault |

## Verification
The hardest cases to reach are those where an earlier check in the priority chain hides a later one. Examples are a no-execute fetch that also misses the page table, and a direct-store access whose table inputs alone would fault. There is also the quiet case of a key-1, field-0 page that still grants a fetch, because execute comes from the segment and not from the key. The stimulus loads a small set of segment registers covering each key, no-execute and direct-store combination. It then walks a vector table in which inputs that lose on priority are deliberately set to values that would change the answer if they were consulted.

// File: rtl/ag_pkg.sv
package ag_pkg;
  localparam int SEG_DS_BIT = 31;
  localparam int SEG_KS_BIT = 30;
  localparam int SEG_KU_BIT = 29;
  localparam int SEG_NX_BIT = 28;

  localparam int PRM_R = 0;
  localparam int PRM_W = 1;
  localparam int PRM_X = 2;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [31:0] ST_PROT_RD = 32'h0800_0000;
  localparam logic [31:0] ST_PROT_WR = 32'h0A00_0000;
  localparam logic [31:0] ST_NOEXEC  = 32'h1000_0000;
  localparam logic [31:0] ST_MISS_RD = 32'h4000_0000;
  localparam logic [31:0] ST_MISS_WR = 32'h4200_0000;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_PROT   = 2'd1,
    CAUSE_NOEXEC = 2'd2,
    CAUSE_MISS   = 2'd3
  } cause_e;

  function automatic logic [2:0] need_of(input logic [1:0] kind);
    logic [2:0] n;
    n = 3'b000;
    case (kind)
      KIND_FETCH: n[PRM_X] = 1'b1;
      KIND_STORE: n[PRM_W] = 1'b1;
      default:    n[PRM_R] = 1'b1;
    endcase
    return n;
  endfunction

  function automatic logic [2:0] block_rights(input logic [1:0] pp);
    logic [2:0] p;
    p = 3'b000;
    if (pp != 2'd0) begin
      p[PRM_R] = 1'b1;
      p[PRM_X] = 1'b1;
      p[PRM_W] = (pp == 2'd2);
    end
    return p;
  endfunction

  function automatic logic [2:0] page_rights(input logic key, input logic [1:0] pp,
                                             input logic nx);
    logic [2:0] p;
    p = 3'b000;
    if (!key) begin
      p[PRM_R] = 1'b1;
      p[PRM_W] = (pp != 2'd3);
    end else begin
      p[PRM_R] = (pp != 2'd0);
      p[PRM_W] = (pp == 2'd2);
    end
    p[PRM_X] = !nx;
    return p;
  endfunction
endpackage

// File: rtl/ag_segfile.sv
module ag_segfile #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && (widx == IDX_W'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/ag_decide.sv
module ag_decide
  import ag_pkg::*;
#(
  parameter int SEG_W = 32
) (
  input  logic [1:0]       kind,
  input  logic             user,
  input  logic             real_mode,
  input  logic [SEG_W-1:0] seg,
  input  logic             blk_hit,
  input  logic [1:0]       blk_pp,
  input  logic             pte_found,
  input  logic [1:0]       pte_pp,
  output logic [2:0]       perm,
  output cause_e           cause
);
  logic [2:0] need;
  logic       key;
  logic       nx;
  logic       dstore;
  logic       is_fetch;

  assign need     = need_of(kind);
  assign key      = user ? seg[SEG_KU_BIT] : seg[SEG_KS_BIT];
  assign nx       = seg[SEG_NX_BIT];
  assign dstore   = seg[SEG_DS_BIT];
  assign is_fetch = (kind == KIND_FETCH);

  always_comb begin
    perm  = 3'b000;
    cause = CAUSE_NONE;
    if (real_mode) begin
      perm = 3'b111;
    end else if (blk_hit) begin
      perm = block_rights(blk_pp);
      if ((need & ~perm) != 3'b000) cause = CAUSE_PROT;
    end else if (dstore) begin
      if (is_fetch) begin
        cause = CAUSE_NOEXEC;
      end else begin
        perm = key ? 3'b011 : 3'b001;
        if ((need & ~perm) != 3'b000) cause = CAUSE_PROT;
      end
    end else if (is_fetch && nx) begin
      cause = CAUSE_NOEXEC;
    end else if (!pte_found) begin
      cause = CAUSE_MISS;
    end else begin
      perm = page_rights(key, pte_pp, nx);
      if ((need & ~perm) != 3'b000) cause = CAUSE_PROT;
    end
  end

  always_comb begin
    if (real_mode) assert_real_clean_R2: assert (cause == CAUSE_NONE);
  end
endmodule

// File: rtl/ag_status.sv
module ag_status
  import ag_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [1:0]        kind,
  input  cause_e            cause,
  output logic              grant,
  output logic              ifault,
  output logic              dfault,
  output logic [STAT_W-1:0] status
);
  logic is_fetch;
  logic is_store;

  assign is_fetch = (kind == KIND_FETCH);
  assign is_store = (kind == KIND_STORE);

  always_comb begin
    grant  = (cause == CAUSE_NONE);
    ifault = !grant && is_fetch;
    dfault = !grant && !is_fetch;
    case (cause)
      CAUSE_PROT:   status = STAT_W'(is_store ? ST_PROT_WR : ST_PROT_RD);
      CAUSE_NOEXEC: status = STAT_W'(ST_NOEXEC);
      CAUSE_MISS:   status = STAT_W'(is_store ? ST_MISS_WR : ST_MISS_RD);
      default:      status = '0;
    endcase
  end
endmodule

// File: rtl/access_guard.sv
module access_guard
  import ag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_IDX_W = 4,
  parameter int SEG_W = 32,
  parameter int STAT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 seg_we,
  input  logic [SEG_IDX_W-1:0] seg_idx,
  input  logic [SEG_W-1:0]     seg_wdata,
  input  logic                 req_vld,
  input  logic [1:0]           req_kind,
  input  logic                 req_user,
  input  logic                 req_real,
  input  logic [ADDR_W-1:0]    req_ea,
  input  logic                 blk_hit,
  input  logic [1:0]           blk_pp,
  input  logic                 pte_found,
  input  logic [1:0]           pte_pp,
  output logic                 rsp_vld,
  output logic                 rsp_grant,
  output logic [2:0]           rsp_perm,
  output logic                 rsp_ifault,
  output logic                 rsp_dfault,
  output logic [STAT_W-1:0]    rsp_status,
  output logic [ADDR_W-1:0]    fault_addr
);
  logic [SEG_IDX_W-1:0] seg_sel;
  logic [SEG_W-1:0]     seg_q;
  logic [2:0]           d_perm;
  cause_e               d_cause;
  logic                 d_grant, d_ifault, d_dfault;
  logic [STAT_W-1:0]    d_status;

  assign seg_sel = req_ea[ADDR_W-1 -: SEG_IDX_W];

  ag_segfile #(.IDX_W(SEG_IDX_W), .DATA_W(SEG_W)) i_segs (
    .clk(clk), .rst(rst), .we(seg_we), .widx(seg_idx), .wdata(seg_wdata),
    .ridx(seg_sel), .rdata(seg_q)
  );

  ag_decide #(.SEG_W(SEG_W)) i_decide (
    .kind(req_kind), .user(req_user), .real_mode(req_real), .seg(seg_q),
    .blk_hit(blk_hit), .blk_pp(blk_pp), .pte_found(pte_found), .pte_pp(pte_pp),
    .perm(d_perm), .cause(d_cause)
  );

  ag_status #(.STAT_W(STAT_W)) i_status (
    .kind(req_kind), .cause(d_cause), .grant(d_grant), .ifault(d_ifault),
    .dfault(d_dfault), .status(d_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld    <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_perm   <= 3'b000;
      rsp_ifault <= 1'b0;
      rsp_dfault <= 1'b0;
      rsp_status <= '0;
      fault_addr <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_grant  <= d_grant;
        rsp_perm   <= d_perm;
        rsp_ifault <= d_ifault;
        rsp_dfault <= d_dfault;
        rsp_status <= d_status;
        if (d_dfault) fault_addr <= req_ea;
      end
    end
  end

  assert_vld_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);
  assert_vld_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> (!rsp_vld && $stable(rsp_status) && $stable(rsp_grant)));
  assert_real_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_real) |=> (rsp_grant && rsp_perm == 3'b111 && rsp_status == '0));
  assert_noexec_fetch_R6: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_real && !blk_hit && req_kind == KIND_FETCH && seg_q[SEG_NX_BIT])
    |=> (rsp_ifault && rsp_status == STAT_W'(ST_NOEXEC)));
  assert_one_fault_R12: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ifault && rsp_dfault));
  assert_grant_clean_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> (!rsp_ifault && !rsp_dfault && rsp_status == '0));
  assert_fetch_side_R12: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_kind == KIND_FETCH) |=> !rsp_dfault);
  assert_far_capture_R13: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> (!rsp_dfault || fault_addr == $past(req_ea)));
  assert_far_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> $stable(fault_addr));
endmodule

// File: tb/test_access_guard.sv
module test_access_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        seg_we;
  logic [3:0]  seg_idx;
  logic [31:0] seg_wdata;
  logic        req_vld;
  logic [1:0]  req_kind;
  logic        req_user, req_real;
  logic [31:0] req_ea;
  logic        blk_hit, pte_found;
  logic [1:0]  blk_pp, pte_pp;
  logic        rsp_vld, rsp_grant, rsp_ifault, rsp_dfault;
  logic [2:0]  rsp_perm;
  logic [31:0] rsp_status, fault_addr;

  int total = 0;
  int bad = 0;
  logic [31:0] far_exp = 32'h0;

  always #2 clk = ~clk;

  access_guard i_access_guard (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_idx(seg_idx), .seg_wdata(seg_wdata),
    .req_vld(req_vld), .req_kind(req_kind), .req_user(req_user), .req_real(req_real),
    .req_ea(req_ea), .blk_hit(blk_hit), .blk_pp(blk_pp), .pte_found(pte_found),
    .pte_pp(pte_pp), .rsp_vld(rsp_vld), .rsp_grant(rsp_grant), .rsp_perm(rsp_perm),
    .rsp_ifault(rsp_ifault), .rsp_dfault(rsp_dfault), .rsp_status(rsp_status),
    .fault_addr(fault_addr)
  );

  localparam logic [1:0] F = 2'd0, L = 2'd1, S = 2'd2;
  localparam logic [31:0] PR = 32'h0800_0000, PW = 32'h0A00_0000, NE = 32'h1000_0000;
  localparam logic [31:0] MR = 32'h4000_0000, MW = 32'h4200_0000, OK = 32'h0;
  // fields: real,user,kind,seg,bhit,bpp,pfound,ppp | grant,perm,ifault,dfault,status
  localparam int NV = 26;
  localparam logic [51:0] VECS [NV] = '{
    {1'b1,1'b0,S,4'd2,1'b1,2'd0,1'b0,2'd0, 1'b1,3'b111,1'b0,1'b0,OK}, // R2 store with block veto present
    {1'b1,1'b1,F,4'd2,1'b0,2'd0,1'b0,2'd0, 1'b1,3'b111,1'b0,1'b0,OK}, // R2 fetch on nx segment
    {1'b0,1'b0,S,4'd0,1'b1,2'd2,1'b0,2'd0, 1'b1,3'b111,1'b0,1'b0,OK}, // R4 pp2 rwx, miss ignored
    {1'b0,1'b0,S,4'd0,1'b1,2'd1,1'b1,2'd2, 1'b0,3'b101,1'b0,1'b1,PW}, // R4 R5 pp1 store
    {1'b0,1'b0,F,4'd0,1'b1,2'd0,1'b1,2'd2, 1'b0,3'b000,1'b1,1'b0,PR}, // R4 R5 pp0 fetch
    {1'b0,1'b0,L,4'd0,1'b1,2'd3,1'b0,2'd0, 1'b1,3'b101,1'b0,1'b0,OK}, // R4 pp3 load
    {1'b0,1'b0,F,4'd3,1'b1,2'd3,1'b0,2'd0, 1'b1,3'b101,1'b0,1'b0,OK}, // R4 block beats direct-store
    {1'b0,1'b0,F,4'd2,1'b0,2'd0,1'b0,2'd0, 1'b0,3'b000,1'b1,1'b0,NE}, // R6 nx before miss
    {1'b0,1'b0,F,4'd0,1'b0,2'd0,1'b0,2'd0, 1'b0,3'b000,1'b1,1'b0,MR}, // R8 fetch miss
    {1'b0,1'b0,L,4'd0,1'b0,2'd0,1'b0,2'd0, 1'b0,3'b000,1'b0,1'b1,MR}, // R8 load miss
    {1'b0,1'b1,S,4'd0,1'b0,2'd0,1'b0,2'd0, 1'b0,3'b000,1'b0,1'b1,MW}, // R8 store miss
    {1'b0,1'b0,S,4'd0,1'b0,2'd0,1'b1,2'd3, 1'b0,3'b101,1'b0,1'b1,PW}, // R10 R5 key0 pp3 store
    {1'b0,1'b0,S,4'd0,1'b0,2'd0,1'b1,2'd2, 1'b1,3'b111,1'b0,1'b0,OK}, // R10 key0 pp2
    {1'b0,1'b1,L,4'd1,1'b0,2'd0,1'b1,2'd0, 1'b0,3'b100,1'b0,1'b1,PR}, // R9 R10 R5 key1 pp0 load
    {1'b0,1'b1,F,4'd1,1'b0,2'd0,1'b1,2'd0, 1'b1,3'b100,1'b0,1'b0,OK}, // R11 key1 pp0 still executes
    {1'b0,1'b0,S,4'd1,1'b0,2'd0,1'b1,2'd0, 1'b1,3'b111,1'b0,1'b0,OK}, // R9 supervisor key0 on seg1
    {1'b0,1'b1,S,4'd1,1'b0,2'd0,1'b1,2'd1, 1'b0,3'b101,1'b0,1'b1,PW}, // R10 key1 pp1 store
    {1'b0,1'b1,S,4'd1,1'b0,2'd0,1'b1,2'd2, 1'b1,3'b111,1'b0,1'b0,OK}, // R10 key1 pp2
    {1'b0,1'b1,L,4'd1,1'b0,2'd0,1'b1,2'd3, 1'b1,3'b101,1'b0,1'b0,OK}, // R10 key1 pp3
    {1'b0,1'b0,L,4'd2,1'b0,2'd0,1'b1,2'd2, 1'b1,3'b011,1'b0,1'b0,OK}, // R11 nx drops execute
    {1'b0,1'b1,S,4'd2,1'b0,2'd0,1'b1,2'd1, 1'b1,3'b011,1'b0,1'b0,OK}, // R9 user key0 on seg2
    {1'b0,1'b0,F,4'd3,1'b0,2'd0,1'b1,2'd2, 1'b0,3'b000,1'b1,1'b0,NE}, // R7 direct-store fetch
    {1'b0,1'b0,S,4'd3,1'b0,2'd0,1'b0,2'd0, 1'b1,3'b011,1'b0,1'b0,OK}, // R7 key1 store
    {1'b0,1'b0,S,4'd4,1'b0,2'd0,1'b1,2'd2, 1'b0,3'b001,1'b0,1'b1,PW}, // R7 key0 store refused
    {1'b0,1'b1,L,4'd3,1'b0,2'd0,1'b0,2'd0, 1'b1,3'b001,1'b0,1'b0,OK}, // R7 key0 load, table ignored
    {1'b0,1'b0,L,4'd15,1'b0,2'd0,1'b1,2'd3,1'b1,3'b001,1'b0,1'b0,OK}  // R9 R11 seg15 sup pp3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seg_write(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    seg_we = 1'b1; seg_idx = idx; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  task automatic issue(input logic rl, input logic us, input logic [1:0] kd,
                       input logic [31:0] ea, input logic bh, input logic [1:0] bp,
                       input logic pf, input logic [1:0] pp);
    @(negedge clk);
    req_vld = 1'b1; req_real = rl; req_user = us; req_kind = kd; req_ea = ea;
    blk_hit = bh; blk_pp = bp; pte_found = pf; pte_pp = pp;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; seg_we = 1'b0; seg_idx = '0; seg_wdata = '0; req_vld = 1'b0;
    req_kind = '0; req_user = 1'b0; req_real = 1'b0; req_ea = '0;
    blk_hit = 1'b0; blk_pp = '0; pte_found = 1'b0; pte_pp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R1 reset rsp_vld", 32'(rsp_vld), 32'd0);
    chk("R12 reset grant", 32'(rsp_grant), 32'd0);
    chk("R12 reset status", rsp_status, 32'h0);
    chk("R13 reset fault_addr", fault_addr, 32'h0);
    // R3 unwritten segment reads zero: fetch pp0 key0 nx clear -> grant rwx
    issue(1'b0, 1'b1, F, 32'h7000_0100, 1'b0, 2'd0, 1'b1, 2'd0);
    chk("R3 reset segment grant", 32'(rsp_grant), 32'd1);
    chk("R3 reset segment perm", 32'(rsp_perm), 32'd7);
    chk("R1 rsp_vld after request", 32'(rsp_vld), 32'd1);
    @(negedge clk);
    chk("R1 rsp_vld drops", 32'(rsp_vld), 32'd0);
    chk("R1 perm held", 32'(rsp_perm), 32'd7);

    seg_write(4'd1, 32'h2000_0000);   // user key
    seg_write(4'd2, 32'h5000_0000);   // supervisor key + nx
    seg_write(4'd3, 32'hC000_0000);   // direct-store + supervisor key
    seg_write(4'd4, 32'h8000_0000);   // direct-store, keys 0
    seg_write(4'd15, 32'h3000_0000);  // user key + nx

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      logic [31:0] ea;
      v = VECS[i];
      ea = {v[47:44], 28'h0ABC000 + 28'(i * 16)};
      issue(v[51], v[50], v[49:48], ea, v[43], v[42:41], v[40], v[39:38]);
      if (v[32]) far_exp = ea;
      chk($sformatf("R1 vector %0d rsp_vld", i), 32'(rsp_vld), 32'd1);
      chk($sformatf("R12 vector %0d grant", i), 32'(rsp_grant), 32'(v[37]));
      chk($sformatf("R4/R10 vector %0d perm", i), 32'(rsp_perm), 32'(v[36:34]));
      chk($sformatf("R12 vector %0d ifault", i), 32'(rsp_ifault), 32'(v[33]));
      chk($sformatf("R12 vector %0d dfault", i), 32'(rsp_dfault), 32'(v[32]));
      chk($sformatf("R5/R8 vector %0d status", i), rsp_status, v[31:0]);
      chk($sformatf("R13 vector %0d fault_addr", i), fault_addr, far_exp);
    end

    // R3 overwrite: seg0 gets nx, fetch now refused with 0x10000000
    seg_write(4'd0, 32'h1000_0000);
    issue(1'b0, 1'b0, F, 32'h0000_2000, 1'b0, 2'd0, 1'b1, 2'd2);
    chk("R3 overwrite ifault", 32'(rsp_ifault), 32'd1);
    chk("R6 overwrite status", rsp_status, NE);
    chk("R13 fault_addr kept on ifault", fault_addr, far_exp);
    // R6 on user access too
    issue(1'b0, 1'b1, F, 32'hF000_0040, 1'b0, 2'd0, 1'b1, 2'd2);
    chk("R6 user nx fetch status", rsp_status, NE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule